// File: doc/BRIEF.md
# Clock Frequency Meter

This block measures how fast one of several free-running clocks runs, using the block's own register clock as the timebase. Software writes a window length, counted in cycles of the clock being measured, and a channel number. It then sets an enable bit. Logic in the measured clock's domain opens a window and closes it after that many of its own cycles. The register-clock domain counts its own cycles from the synchronised window start to the synchronised window end.

When the window closes, the count is latched into a value register and a valid status bit rises. Software computes the measured frequency as reference frequency × window length / result. A zero result marks a failed measurement. The meter gives a zero result when the measured clock never produces a window within the timeout. It does the same when the measurement clock gate in the status register is off.

Each monitored channel has its own window counter, clocked by that channel's clock, so no clock is ever switched through a multiplexer. Only the synchronised window flags are selected, and this happens in the register domain.

Top module: `fm_clk_meter`

## Requirements
- R1: After reset, the control register (0x00), the value register (0x0C) and the status register (0x10) all read zero.
- R2: The control register keeps the window length in bits [23:0], the enable in bit 24 and the channel number in bits [27:26]; all other bits read zero. In the status register, bit 8 is the measurement clock gate and can be read and written, while bit 0 is valid and is read-only, so writing it has no effect. A read from any other offset returns zero.
- R3: With the clock gate and the enable set, valid (status bit 0) rises once the window has closed. The value register then holds the number of reference cycles in the window, within ±2 of length × monitored period / reference period.
- R4: The channel field selects which monitored clock is measured; each channel gives its own period ratio.
- R5: A window length of zero is treated as one monitored cycle and gives a small nonzero result.
- R6: Clearing the enable aborts any window in progress, and valid reads zero no later than the second reference edge after the write. Setting the enable again starts a fresh count from zero.
- R7: The value register keeps its last result until another window completes; an abort does not change it.
- R8: The result saturates at all ones (2^RES_W-1) and does not wrap.
- R9: If the selected clock never toggles, valid rises with a result of zero after 2^TMO_W reference cycles.
- R10: With the clock gate (status bit 8) clear, no window opens, and an enabled measurement ends by timeout with a result of zero.
- R11: Valid stays set for as long as the enable stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference and register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mon_clk_i | input | NCH | Monitored clocks, one per channel |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |

## Verification
The main function is tried on three running channels. Their periods are 10 ns, 6 ns and 14 ns, with window lengths of 1024, 200 and 100. Matching each result to its own ratio shows that the select routes the right clock and that the count scales with both the period and the length.

A zero-length window separates the one-cycle floor from a failed measurement. A 24 ns clock with a long window reaches the saturation ceiling before the timeout. A stopped clock and a closed clock gate each have to end in a zero result after the full timeout, and not early.

An abort in the middle of a window is followed by a restart with the same settings. The restart must reproduce the full-length result, and the value register must not change across the abort.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 32;
  localparam int LEN_W     = 24;
  localparam int SEL_W     = 2;
  localparam int EN_BIT    = 24;
  localparam int SEL_LO    = 26;
  localparam int VALID_BIT = 0;
  localparam int GATE_BIT  = 8;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_VALUE = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 5'h10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_COUNT,
    ST_DONE
  } fm_state_e;
endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/fm_mon_window.sv
// Runs in one monitored clock domain: opens a window of len_i own cycles once armed.
module fm_mon_window #(
  parameter int LEN_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             win_o,
  output logic             done_o
);
  logic             arm_s;
  logic [LEN_W-1:0] cnt_q, cnt_nxt, len_eff;
  logic             win_q, done_q;

  fm_sync #(.W(1)) u_arm_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (arm_i),
    .q_o   (arm_s)
  );

  assign len_eff = (len_i == '0) ? LEN_W'(1) : len_i;
  assign cnt_nxt = cnt_q + LEN_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!arm_s) begin
      win_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!win_q && !done_q) begin
      win_q <= 1'b1;
      cnt_q <= '0;
    end else if (win_q) begin
      if (cnt_nxt == len_eff) begin
        win_q  <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  assign win_o  = win_q;
  assign done_o = done_q;

  // R6: a dropped arm clears the window state
  p_win_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_s |=> (!win_q && !done_q));
  // R3: window open and window closed never coexist
  p_win_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(win_q && done_q));
endmodule

// File: rtl/fm_ref_meter.sv
// Reference-domain counter: start on window edge, latch on close, timeout on silence.
module fm_ref_meter
  import fm_pkg::*;
#(
  parameter int RES_W = 24,
  parameter int TMO_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             win_s_i,
  input  logic             done_s_i,
  output logic             valid_o,
  output logic             load_o,
  output logic [RES_W-1:0] load_val_o
);
  fm_state_e        state_q, state_n;
  logic [RES_W-1:0] res_q, res_n, res_inc;
  logic [TMO_W-1:0] tmo_q, tmo_n;
  logic             win_prev_q, done_prev_q;
  logic             win_rise, done_rise, tmo_hit;

  assign win_rise  = win_s_i & ~win_prev_q;
  assign done_rise = done_s_i & ~done_prev_q;
  assign tmo_hit   = (tmo_q == '1);
  assign res_inc   = (res_q == '1) ? res_q : res_q + RES_W'(1);

  always_comb begin
    state_n    = state_q;
    res_n      = res_q;
    tmo_n      = tmo_q;
    load_o     = 1'b0;
    load_val_o = '0;
    if (!en_i) begin
      state_n = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_n = ST_WAIT;
          tmo_n   = '0;
          res_n   = '0;
        end
        ST_WAIT: begin
          tmo_n = tmo_q + TMO_W'(1);
          if (done_rise) begin
            state_n    = ST_DONE;
            load_o     = 1'b1;
            load_val_o = RES_W'(1);
          end else if (win_rise) begin
            state_n = ST_COUNT;
            res_n   = '0;
          end else if (tmo_hit) begin
            state_n = ST_DONE;
            load_o  = 1'b1;
          end
        end
        ST_COUNT: begin
          tmo_n = tmo_q + TMO_W'(1);
          if (done_rise) begin
            state_n    = ST_DONE;
            load_o     = 1'b1;
            load_val_o = res_inc;
          end else if (tmo_hit) begin
            state_n = ST_DONE;
            load_o  = 1'b1;
          end else begin
            res_n = res_inc;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      res_q       <= '0;
      tmo_q       <= '0;
      win_prev_q  <= 1'b0;
      done_prev_q <= 1'b0;
    end else begin
      state_q     <= state_n;
      res_q       <= res_n;
      tmo_q       <= tmo_n;
      win_prev_q  <= win_s_i;
      done_prev_q <= done_s_i;
    end
  end

  assign valid_o = (state_q == ST_DONE);

  p_valid_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o);
  p_valid_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && en_i) |=> valid_o);
  p_no_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == ST_COUNT && res_q == '1 && !done_rise && !tmo_hit) |=> (res_q == '1));
  p_timeout_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == ST_WAIT && tmo_hit && !win_rise && !done_rise) |=> valid_o);
endmodule

// File: rtl/fm_regs.sv
module fm_regs
  import fm_pkg::*;
#(
  parameter int RES_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              en_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              gate_o,
  input  logic              valid_i,
  input  logic              load_i,
  input  logic [RES_W-1:0]  load_val_i
);
  logic [LEN_W-1:0] len_q;
  logic             en_q, gate_q;
  logic [SEL_W-1:0] sel_q;
  logic [RES_W-1:0] value_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      en_q   <= 1'b0;
      sel_q  <= '0;
      gate_q <= 1'b0;
    end else if (we_i) begin
      if (addr_i == OFF_CTRL) begin
        len_q <= wdata_i[LEN_W-1:0];
        en_q  <= wdata_i[EN_BIT];
        sel_q <= wdata_i[SEL_LO +: SEL_W];
      end
      if (addr_i == OFF_STAT) gate_q <= wdata_i[GATE_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     value_q <= '0;
    else if (load_i) value_q <= load_val_i;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_CTRL: begin
        rdata_o[LEN_W-1:0]        = len_q;
        rdata_o[EN_BIT]           = en_q;
        rdata_o[SEL_LO +: SEL_W]  = sel_q;
      end
      OFF_VALUE: rdata_o = DATA_W'(value_q);
      OFF_STAT: begin
        rdata_o[VALID_BIT] = valid_i;
        rdata_o[GATE_BIT]  = gate_q;
      end
      default: ;
    endcase
  end

  assign len_o  = len_q;
  assign en_o   = en_q;
  assign sel_o  = sel_q;
  assign gate_o = gate_q;

  p_value_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(value_q));
endmodule

// File: rtl/fm_clk_meter.sv
module fm_clk_meter
  import fm_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int RES_W = 24,
  parameter int TMO_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    mon_clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [LEN_W-1:0] len;
  logic             en, gate, valid, load;
  logic [SEL_W-1:0] sel;
  logic [RES_W-1:0] load_val;
  logic [NCH-1:0]   arm, win, done, win_s, done_s;
  logic             win_sel, done_sel;

  fm_regs #(.RES_W(RES_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .len_o     (len),
    .en_o      (en),
    .sel_o     (sel),
    .gate_o    (gate),
    .valid_i   (valid),
    .load_i    (load),
    .load_val_i(load_val)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign arm[i] = en & gate & (sel == SEL_W'(i));

    fm_mon_window #(.LEN_W(LEN_W)) u_win (
      .clk_i (mon_clk_i[i]),
      .rst_ni(rst_ni),
      .arm_i (arm[i]),
      .len_i (len),
      .win_o (win[i]),
      .done_o(done[i])
    );

    fm_sync #(.W(2)) u_back_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   ({win[i], done[i]}),
      .q_o   ({win_s[i], done_s[i]})
    );
  end

  always_comb begin
    win_sel  = 1'b0;
    done_sel = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (sel == SEL_W'(i)) begin
        win_sel  = win_s[i];
        done_sel = done_s[i];
      end
    end
  end

  fm_ref_meter #(.RES_W(RES_W), .TMO_W(TMO_W)) u_meter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .win_s_i   (win_sel),
    .done_s_i  (done_sel),
    .valid_o   (valid),
    .load_o    (load),
    .load_val_o(load_val)
  );

  // R2: control readback never shows bits outside the defined fields
  p_ctrl_fields_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_CTRL) |-> (rdata_o[31:28] == 4'b0 && rdata_o[25] == 1'b0));
endmodule

// File: tb/fm_clk_meter_tb.sv
`timescale 1ns/1ps
module fm_clk_meter_tb;
  localparam int RES_W = 12;
  localparam int TMO_W = 14;
  localparam int RES_MAX = (1 << RES_W) - 1;
  localparam logic [4:0] A_CTRL = 5'h00, A_VAL = 5'h0C, A_STAT = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mclk = 4'b0;
  logic        run3 = 1'b1;
  logic        we = 1'b0;
  logic [4:0]  addr = 5'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0, fails = 0;
  logic [31:0] ctrl_m = '0;
  logic        gate_m = 1'b0;
  int          en_low = 0;
  int          last_val = 0;

  always #2 clk = ~clk;
  initial forever #5 mclk[0] = ~mclk[0];
  initial forever #3 mclk[1] = ~mclk[1];
  initial forever #7 mclk[2] = ~mclk[2];
  initial forever begin #12; if (run3) mclk[3] = ~mclk[3]; end

  fm_clk_meter #(.NCH(4), .RES_W(RES_W), .TMO_W(TMO_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mon_clk_i(mclk),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [31:0] mk_ctrl(int len, bit en, int sel);
    return {4'b0, 2'(sel), 1'b0, en, 24'(len)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    if (a == A_CTRL) ctrl_m = d & 32'h0DFF_FFFF;
    if (a == A_STAT) gate_m = d[8];
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic poll(int limit, output int cyc, output bit got);
    logic [31:0] s;
    got = 1'b0; cyc = 0;
    while (cyc < limit && !got) begin
      rd(A_STAT, s);
      got = s[0];
      cyc++;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // per-clock model comparison of register readback
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (ctrl_m[24]) en_low = 0; else en_low++;
      if (addr == A_CTRL) chk(rdata == ctrl_m, "R2", int'(rdata), int'(ctrl_m));
      if (addr == A_STAT) begin
        chk(rdata[8] == gate_m, "R2", int'(rdata[8]), int'(gate_m));
        if (en_low >= 2) chk(rdata[0] == 1'b0, "R6", int'(rdata[0]), 0);
      end
    end
  end

  task automatic measure(int sel, int len, int lo, int hi, string req);
    logic [31:0] d; int cyc; bit got;
    wr(A_CTRL, mk_ctrl(len, 1'b1, sel));
    poll(20000, cyc, got);
    chk(got, req, int'(got), 1);
    rd(A_VAL, d);
    chk(int'(d) >= lo && int'(d) <= hi, req, int'(d), (lo + hi) / 2);
    last_val = int'(d);
    idle(100);
    rd(A_STAT, d);
    chk(d[0] == 1'b1, "R11", int'(d[0]), 1);
    wr(A_CTRL, mk_ctrl(len, 1'b0, sel));
    idle(30);
  endtask

  initial begin
    logic [31:0] d; int cyc; bit got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(A_CTRL, d); chk(d == 0, "R1", int'(d), 0);
    rd(A_VAL, d);  chk(d == 0, "R1", int'(d), 0);
    rd(A_STAT, d); chk(d == 0, "R1", int'(d), 0);

    wr(A_CTRL, 32'hF2FF_1234);
    rd(A_CTRL, d); chk(d == 32'h00FF_1234, "R2", int'(d), 32'h00FF_1234);
    wr(A_STAT, 32'h0000_0101);
    rd(A_STAT, d); chk(d == 32'h0000_0100, "R2", int'(d), 32'h100);
    rd(5'h04, d);  chk(d == 0, "R2", int'(d), 0);
    wr(A_CTRL, 32'h0);

    // len*Tmon/Tref with Tref=4 ns
    measure(0, 1024, 2558, 2562, "R3");
    measure(1, 200, 298, 302, "R4");
    measure(2, 100, 348, 352, "R4");
    measure(1, 0, 1, 4, "R5");

    // abort mid-window, then restart
    wr(A_CTRL, mk_ctrl(1024, 1'b1, 0));
    idle(300);
    wr(A_CTRL, mk_ctrl(1024, 1'b0, 0));
    rd(A_STAT, d); chk(d[0] == 1'b0, "R6", int'(d[0]), 0);
    rd(A_VAL, d);  chk(int'(d) == last_val, "R7", int'(d), last_val);
    idle(30);
    measure(0, 1024, 2558, 2562, "R6");

    measure(3, 1000, RES_MAX, RES_MAX, "R8");

    // gate closed: timeout with zero
    wr(A_STAT, 32'h0);
    wr(A_CTRL, mk_ctrl(64, 1'b1, 0));
    poll(20000, cyc, got);
    chk(got, "R10", int'(got), 1);
    chk(cyc >= 16000, "R10", cyc, 16384);
    rd(A_VAL, d); chk(d == 0, "R10", int'(d), 0);
    wr(A_CTRL, mk_ctrl(64, 1'b0, 0));
    wr(A_STAT, 32'h100);
    idle(30);

    // stopped clock: timeout with zero
    run3 = 1'b0;
    idle(20);
    wr(A_CTRL, mk_ctrl(10, 1'b1, 3));
    poll(20000, cyc, got);
    chk(got, "R9", int'(got), 1);
    chk(cyc >= 16000, "R9", cyc, 16384);
    rd(A_VAL, d); chk(d == 0, "R9", int'(d), 0);
    wr(A_CTRL, mk_ctrl(10, 1'b0, 3));
    idle(5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule